// File: doc/BRIEF.md
# Exception Vector and Return-Pointer Unit

This block sits at the retire stage of a simple in-order CPU pipeline. Each retiring instruction arrives with a set of event flags from the pipeline, along with its own address and the address of the instruction after it. The block turns those flags into at most one delivered exception. It reports the vector number, the class of that vector (fault, trap or interrupt) and the instruction pointer that the handler must save.

Faults save the address of the offending instruction, so that instruction runs again on return. Traps and the non-maskable interrupt save the address of the following instruction. A non-maskable interrupt request is latched and waits for an instruction boundary.

The block does no decoding. It checks the operands of a bounds check, the overflow status flag of an overflow-check instruction, and the opcode byte of an instruction the decoder marked invalid. It then announces the winner with a one-cycle pulse and holds the result until the dispatch logic acknowledges it.

The controller has three named states:
- `ST_IDLE`: accepting retires.
- `ST_ISSUE`: the single pulse cycle.
- `ST_HOLD`: waiting for acknowledge.

It has four transitions:
- *capture*: `ST_IDLE` to `ST_ISSUE`, on a retire with at least one qualified event.
- *linger*: `ST_ISSUE` to `ST_HOLD`, with no acknowledge.
- *release*: `ST_ISSUE` or `ST_HOLD` to `ST_IDLE`, on acknowledge.
- *wait*: `ST_HOLD` to `ST_HOLD`.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, `deliver_o`, `vector_o`, `class_o`, `saved_ip_o` and `errcode_o` are all 0, and no NMI is pending.
- R2: Event flags have no effect unless `retire_i` is high in `ST_IDLE`. A flagged invalid opcode on a squashed instruction (no retire) produces no delivery.
- R3: Vectors 5 (bounds), 6 (invalid opcode) and 7 (device not available) are faults. They are reported with `class_o` = 0 and `saved_ip_o` equal to the `cur_ip_i` of the retiring instruction.
- R4: Vector 3 (breakpoint, `brk_i`) and vector 4 (overflow check) are traps. They are reported with `class_o` = 1 and `saved_ip_o` equal to `next_ip_i`.
- R5: `ovchk_i` raises vector 4 only when `of_flag_i` is 1. With `of_flag_i` at 0 there is no delivery.
- R6: `bnd_chk_i` raises vector 5 only when the signed index is strictly below the lower bound or strictly above the upper bound. An index equal to either bound does not fault.
- R7: `badop_i` raises vector 6 unless `opcode_i` is 8'hD6 or 8'hF1. `undef_i` raises vector 6 whatever the opcode byte is.
- R8: When several events qualify on one instruction, any fault beats any trap or interrupt. Among faults the lowest vector wins, and among traps vector 3 beats vector 4.
- R9: A rising edge on `nmi_i` sets a pending request. On a later retire with no qualified fault or trap, vector 2 is delivered with `class_o` = 2 and `saved_ip_o` = `next_ip_i`, and the request clears. A fault or trap on that retire is delivered first, and the request stays pending.
- R10: `deliver_o` is high for exactly the one cycle after the capturing clock edge. The outputs then hold until `ack_i` is seen in `ST_ISSUE` or `ST_HOLD`. Retires seen before that are ignored.
- R11: `errcode_o` is 0 for every vector from 2 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | The instruction on the flag inputs retires this cycle |
| cur_ip_i | input | AW | Address of the retiring instruction |
| next_ip_i | input | AW | Address of the instruction after it |
| brk_i | input | 1 | Single-byte breakpoint executed |
| ovchk_i | input | 1 | Overflow-check instruction executed |
| of_flag_i | input | 1 | Overflow status flag seen by that instruction |
| bnd_chk_i | input | 1 | Bounds-check instruction executed |
| bnd_idx_i | input | DW | Signed index under test |
| bnd_lo_i | input | DW | Signed lower bound |
| bnd_hi_i | input | DW | Signed upper bound |
| badop_i | input | 1 | Decoder marked the opcode invalid |
| undef_i | input | 1 | Dedicated always-undefined instruction |
| opcode_i | input | 8 | First opcode byte of the retiring instruction |
| devna_i | input | 1 | Coprocessor/vector unit not available |
| nmi_i | input | 1 | Non-maskable interrupt request, edge sensitive |
| ack_i | input | 1 | Dispatch has taken the delivered exception |
| deliver_o | output | 1 | One-cycle delivery pulse |
| vector_o | output | 8 | Delivered vector number |
| class_o | output | 2 | 0 fault, 1 trap, 2 interrupt |
| saved_ip_o | output | AW | Instruction pointer to save |
| errcode_o | output | 1 | An error code accompanies the vector |

## Verification
The two functions that meet in one cycle are NMI delivery and the fault/trap arbitration of a retiring instruction. The bench raises `nmi_i` and then retires instructions that carry a fault, a trap, or nothing at all. A behavioural model, updated on every clock, decides the expected vector and saved pointer, and the design is compared against it on each falling edge. A second collision the bench provokes is acknowledge and delivery in the same cycle, directly followed by a fresh retire.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W = 8;

    localparam logic [VEC_W-1:0] VEC_NMI   = 8'd2;
    localparam logic [VEC_W-1:0] VEC_BRK   = 8'd3;
    localparam logic [VEC_W-1:0] VEC_OVF   = 8'd4;
    localparam logic [VEC_W-1:0] VEC_BND   = 8'd5;
    localparam logic [VEC_W-1:0] VEC_UD    = 8'd6;
    localparam logic [VEC_W-1:0] VEC_DEVNA = 8'd7;

    // opcode bytes that are reserved yet never raise the invalid-opcode fault
    localparam logic [7:0] OPC_QUIET_A = 8'hD6;
    localparam logic [7:0] OPC_QUIET_B = 8'hF1;

    typedef enum logic [1:0] {
        CLS_FAULT = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_INTR  = 2'd2
    } exc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } ctl_state_e;

    // class attached to each vector number
    function automatic exc_class_e class_of(input logic [VEC_W-1:0] v);
        if (v == VEC_NMI)                       return CLS_INTR;
        else if (v == VEC_BRK || v == VEC_OVF)  return CLS_TRAP;
        else                                    return CLS_FAULT;
    endfunction

    // vectors that push an error code; none of 2..7 do
    function automatic logic has_errcode(input logic [VEC_W-1:0] v);
        return (v == 8'd8) || (v >= 8'd10 && v <= 8'd14) || (v == 8'd17);
    endfunction

endpackage

// File: rtl/exc_detect.sv
module exc_detect
    import exc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NVEC = 8
) (
    input  logic            nmi_pend_i,
    input  logic            brk_i,
    input  logic            ovchk_i,
    input  logic            of_flag_i,
    input  logic            bnd_chk_i,
    input  logic [DW-1:0]   bnd_idx_i,
    input  logic [DW-1:0]   bnd_lo_i,
    input  logic [DW-1:0]   bnd_hi_i,
    input  logic            badop_i,
    input  logic            undef_i,
    input  logic [7:0]      opcode_i,
    input  logic            devna_i,
    output logic [NVEC-1:0] raise_o
);

    logic below_lo;
    logic above_hi;
    logic quiet_opc;

    // signed range test of the bounds check
    always_comb begin
        below_lo = $signed(bnd_idx_i) < $signed(bnd_lo_i);
        above_hi = $signed(bnd_idx_i) > $signed(bnd_hi_i);
    end

    assign quiet_opc = (opcode_i == OPC_QUIET_A) || (opcode_i == OPC_QUIET_B);

    always_comb begin
        raise_o             = '0;
        raise_o[VEC_NMI]    = nmi_pend_i;
        raise_o[VEC_BRK]    = brk_i;
        raise_o[VEC_OVF]    = ovchk_i & of_flag_i;
        raise_o[VEC_BND]    = bnd_chk_i & (below_lo | above_hi);
        raise_o[VEC_UD]     = undef_i | (badop_i & ~quiet_opc);
        raise_o[VEC_DEVNA]  = devna_i;
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NVEC = 8
) (
    input  logic [NVEC-1:0]  raise_i,
    input  logic [AW-1:0]    cur_ip_i,
    input  logic [AW-1:0]    next_ip_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o,
    output exc_class_e       cls_o,
    output logic [AW-1:0]    ip_o,
    output logic             errcode_o
);

    logic [NVEC-1:0] is_fault;
    logic [NVEC-1:0] is_trap;
    logic [NVEC-1:0] is_intr;
    logic [NVEC-1:0] m_fault;
    logic [NVEC-1:0] m_trap;
    logic [NVEC-1:0] m_intr;

    // static class masks, one bit per vector
    for (genvar g = 0; g < NVEC; g++) begin : g_cls
        assign is_fault[g] = (class_of(VEC_W'(g)) == CLS_FAULT);
        assign is_trap[g]  = (class_of(VEC_W'(g)) == CLS_TRAP);
        assign is_intr[g]  = (class_of(VEC_W'(g)) == CLS_INTR);
    end

    function automatic logic [VEC_W-1:0] lowest(input logic [NVEC-1:0] m);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (m[i]) r = VEC_W'(i);
        end
        return r;
    endfunction

    assign m_fault = raise_i & is_fault;
    assign m_trap  = raise_i & is_trap;
    assign m_intr  = raise_i & is_intr;
    assign any_o   = |raise_i;

    // faults preempt completion; traps of the completed instruction
    // precede an interrupt taken at the same boundary
    always_comb begin
        vec_o = '0;
        cls_o = CLS_FAULT;
        ip_o  = cur_ip_i;
        if (|m_fault) begin
            vec_o = lowest(m_fault);
            cls_o = CLS_FAULT;
            ip_o  = cur_ip_i;
        end else if (|m_trap) begin
            vec_o = lowest(m_trap);
            cls_o = CLS_TRAP;
            ip_o  = next_ip_i;
        end else if (|m_intr) begin
            vec_o = lowest(m_intr);
            cls_o = CLS_INTR;
            ip_o  = next_ip_i;
        end
    end

    assign errcode_o = has_errcode(vec_o);

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             any_i,
    input  logic [VEC_W-1:0] vec_i,
    input  exc_class_e       cls_i,
    input  logic [AW-1:0]    ip_i,
    input  logic             errcode_i,
    input  logic             nmi_i,
    input  logic             ack_i,
    output logic             nmi_pend_o,
    output logic             idle_o,
    output logic             deliver_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [1:0]       cls_o,
    output logic [AW-1:0]    ip_o,
    output logic             errcode_o
);

    ctl_state_e       state_q, state_d;
    logic             capture;
    logic             take_nmi;
    logic             nmi_q;
    logic             pend_q;
    logic [VEC_W-1:0] vec_q;
    exc_class_e       cls_q;
    logic [AW-1:0]    ip_q;
    logic             err_q;

    assign capture  = (state_q == ST_IDLE) && retire_i && any_i;
    assign take_nmi = capture && (vec_i == VEC_NMI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: capture, linger, release, wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (capture) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ack_i ? ST_IDLE : ST_HOLD;
            ST_HOLD:  if (ack_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // held result, loaded only on capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            cls_q <= CLS_FAULT;
            ip_q  <= '0;
            err_q <= 1'b0;
        end else if (capture) begin
            vec_q <= vec_i;
            cls_q <= cls_i;
            ip_q  <= ip_i;
            err_q <= errcode_i;
        end
    end

    // edge-sensitive NMI latch; a new edge outranks a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            nmi_q  <= nmi_i;
            pend_q <= (pend_q & ~take_nmi) | (nmi_i & ~nmi_q);
        end
    end

    // outputs
    always_comb begin
        deliver_o  = (state_q == ST_ISSUE);
        idle_o     = (state_q == ST_IDLE);
        nmi_pend_o = pend_q;
        vec_o      = vec_q;
        cls_o      = cls_q;
        ip_o       = ip_q;
        errcode_o  = err_q;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_o |=> !deliver_o); // R10
    AST_CAPTURE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && retire_i && any_i) |=> deliver_o); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && !ack_i) |=> ($stable(vec_o) && $stable(ip_o) && $stable(cls_o))); // R10
    AST_NO_RETIRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !retire_i) |=> !deliver_o); // R2
    AST_NMI_EDGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_i && !nmi_q) |=> nmi_pend_o); // R9

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 16,
    parameter int NVEC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire_i,
    input  logic [AW-1:0] cur_ip_i,
    input  logic [AW-1:0] next_ip_i,
    input  logic          brk_i,
    input  logic          ovchk_i,
    input  logic          of_flag_i,
    input  logic          bnd_chk_i,
    input  logic [DW-1:0] bnd_idx_i,
    input  logic [DW-1:0] bnd_lo_i,
    input  logic [DW-1:0] bnd_hi_i,
    input  logic          badop_i,
    input  logic          undef_i,
    input  logic [7:0]    opcode_i,
    input  logic          devna_i,
    input  logic          nmi_i,
    input  logic          ack_i,
    output logic          deliver_o,
    output logic [7:0]    vector_o,
    output logic [1:0]    class_o,
    output logic [AW-1:0] saved_ip_o,
    output logic          errcode_o
);

    logic [NVEC-1:0]  raise;
    logic             nmi_pend;
    logic             idle;
    logic             any;
    logic [VEC_W-1:0] arb_vec;
    exc_class_e       arb_cls;
    logic [AW-1:0]    arb_ip;
    logic             arb_err;

    exc_detect #(.DW(DW), .NVEC(NVEC)) u_detect (
        .nmi_pend_i (nmi_pend),
        .brk_i      (brk_i),
        .ovchk_i    (ovchk_i),
        .of_flag_i  (of_flag_i),
        .bnd_chk_i  (bnd_chk_i),
        .bnd_idx_i  (bnd_idx_i),
        .bnd_lo_i   (bnd_lo_i),
        .bnd_hi_i   (bnd_hi_i),
        .badop_i    (badop_i),
        .undef_i    (undef_i),
        .opcode_i   (opcode_i),
        .devna_i    (devna_i),
        .raise_o    (raise)
    );

    exc_arbiter #(.AW(AW), .NVEC(NVEC)) u_arb (
        .raise_i   (raise),
        .cur_ip_i  (cur_ip_i),
        .next_ip_i (next_ip_i),
        .any_o     (any),
        .vec_o     (arb_vec),
        .cls_o     (arb_cls),
        .ip_o      (arb_ip),
        .errcode_o (arb_err)
    );

    exc_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_i   (retire_i),
        .any_i      (any),
        .vec_i      (arb_vec),
        .cls_i      (arb_cls),
        .ip_i       (arb_ip),
        .errcode_i  (arb_err),
        .nmi_i      (nmi_i),
        .ack_i      (ack_i),
        .nmi_pend_o (nmi_pend),
        .idle_o     (idle),
        .deliver_o  (deliver_o),
        .vec_o      (vector_o),
        .cls_o      (class_o),
        .ip_o       (saved_ip_o),
        .errcode_o  (errcode_o)
    );

    AST_FAULT_SAVES_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && class_o == 2'd0) |-> (saved_ip_o == $past(cur_ip_i))); // R3
    AST_TRAP_SAVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && class_o == 2'd1) |-> (saved_ip_o == $past(next_ip_i))); // R4
    AST_NMI_SAVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && vector_o == 8'd2) |-> (class_o == 2'd2 && saved_ip_o == $past(next_ip_i))); // R9
    AST_NO_ERRCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && vector_o >= 8'd2 && vector_o <= 8'd7) |-> !errcode_o); // R11
    AST_QUIET_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && retire_i && badop_i && !undef_i && !nmi_pend && !brk_i && !ovchk_i
         && !bnd_chk_i && !devna_i && (opcode_i == 8'hD6 || opcode_i == 8'hF1))
        |=> !deliver_o); // R7
    AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && vector_o == 8'd4) |-> $past(of_flag_i)); // R5

endmodule

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;

    localparam int AW = 32;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retire = 1'b0;
    logic [AW-1:0] cur_ip = '0, next_ip = '0;
    logic brk = 0, ovchk = 0, of_flag = 0, bnd = 0, badop = 0, undef = 0, devna = 0, nmi = 0, ack = 0;
    logic signed [DW-1:0] idx = '0, lo = '0, hi = '0;
    logic [7:0] opcode = 8'h90;

    wire deliver, errcode;
    wire [7:0] vector;
    wire [1:0] cls;
    wire [AW-1:0] saved;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit armed = 0;
    bit done = 0;

    // reference model state
    int m_state = 0;
    bit m_pend = 0, m_nmiq = 0;
    int m_vec = 0, m_cls = 0;
    logic [AW-1:0] m_ip = '0;

    exc_vector_unit #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .cur_ip_i(cur_ip), .next_ip_i(next_ip),
        .brk_i(brk), .ovchk_i(ovchk), .of_flag_i(of_flag), .bnd_chk_i(bnd),
        .bnd_idx_i(idx), .bnd_lo_i(lo), .bnd_hi_i(hi), .badop_i(badop), .undef_i(undef),
        .opcode_i(opcode), .devna_i(devna), .nmi_i(nmi), .ack_i(ack),
        .deliver_o(deliver), .vector_o(vector), .class_o(cls), .saved_ip_o(saved),
        .errcode_o(errcode)
    );

    always #2 clk = ~clk;

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pend = 0; m_nmiq = 0; m_vec = 0; m_cls = 0; m_ip = '0;
        end else begin
            bit rise, take;
            int v;
            rise = nmi && !m_nmiq;
            m_nmiq = nmi;
            take = 0;
            if (m_state == 0) begin
                if (retire) begin
                    v = 0;
                    if (bnd && (idx < lo || idx > hi))                     v = 5;
                    else if (undef || (badop && opcode != 8'hD6 && opcode != 8'hF1)) v = 6;
                    else if (devna)                                        v = 7;
                    else if (brk)                                          v = 3;
                    else if (ovchk && of_flag)                             v = 4;
                    else if (m_pend)                                       v = 2;
                    if (v != 0) begin
                        m_state = 1;
                        m_vec = v;
                        m_cls = (v >= 5) ? 0 : (v == 2 ? 2 : 1);
                        m_ip = (v >= 5) ? cur_ip : next_ip;
                        take = (v == 2);
                    end
                end
            end else if (ack) m_state = 0;
            else m_state = 2;
            m_pend = (m_pend && !take) || rise;
        end
    end

    // compare on every falling edge once reset is released
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (deliver !== (m_state == 1) || vector !== 8'(m_vec) || cls !== 2'(m_cls)
                || saved !== m_ip || errcode !== 1'b0) begin
                fails++;
                $display("FAIL %s: deliver=%0b/%0b vec=%0d/%0d class=%0d/%0d ip=%h/%h err=%0b/0 (actual/expected)",
                         cur_req, deliver, (m_state == 1), vector, m_vec, cls, m_cls, saved, m_ip, errcode);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic clear_ev();
        retire = 0; brk = 0; ovchk = 0; of_flag = 0; bnd = 0; badop = 0; undef = 0; devna = 0;
        opcode = 8'h90;
    endtask

    task automatic set_ip(input logic [AW-1:0] a, input int len);
        cur_ip = a; next_ip = a + AW'(len);
    endtask

    // retire what is on the flags, wait, acknowledge
    task automatic run_instr();
        retire = 1; tick(1);
        clear_ev(); tick(2);
        ack = 1; tick(1);
        ack = 0; tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1; armed = 1;
        cur_req = "R1"; tick(2);

        cur_req = "R2";                      // squashed invalid opcode: no retire
        badop = 1; opcode = 8'h0B; devna = 1; set_ip(32'h100, 2); tick(3); clear_ev(); tick(1);

        cur_req = "R6"; lo = -5; hi = 10; set_ip(32'h200, 3);
        bnd = 1; idx = -5;  run_instr();
        bnd = 1; idx = 10;  run_instr();
        bnd = 1; idx = -6;  run_instr();
        bnd = 1; idx = 11;  set_ip(32'h210, 3); run_instr();

        cur_req = "R7"; set_ip(32'h300, 2);
        badop = 1; opcode = 8'h0F; run_instr();
        badop = 1; opcode = 8'hD6; run_instr();
        badop = 1; opcode = 8'hF1; run_instr();
        undef = 1; opcode = 8'hD6; set_ip(32'h310, 2); run_instr();

        cur_req = "R3"; set_ip(32'h400, 4);
        devna = 1; run_instr();

        cur_req = "R4"; set_ip(32'h500, 1);
        brk = 1; run_instr();
        cur_req = "R5"; set_ip(32'h510, 1);
        ovchk = 1; of_flag = 0; run_instr();
        ovchk = 1; of_flag = 1; run_instr();

        cur_req = "R8"; set_ip(32'h600, 3); lo = 0; hi = 3; idx = 9;
        bnd = 1; badop = 1; opcode = 8'h27; devna = 1; brk = 1; run_instr();
        badop = 1; opcode = 8'h27; devna = 1; run_instr();
        devna = 1; brk = 1; ovchk = 1; of_flag = 1; run_instr();
        brk = 1; ovchk = 1; of_flag = 1; set_ip(32'h610, 1); run_instr();

        cur_req = "R9"; set_ip(32'h700, 2);
        nmi = 1; tick(1); nmi = 0; tick(1);
        run_instr();                          // clean retire takes vector 2
        nmi = 1; tick(1); nmi = 0; tick(1);
        devna = 1; set_ip(32'h710, 2); run_instr();   // fault first, NMI waits
        brk = 1; set_ip(32'h720, 1); run_instr();     // trap first, NMI still waits
        set_ip(32'h730, 5); run_instr();               // now vector 2
        run_instr();                                   // nothing left

        cur_req = "R10"; set_ip(32'h800, 1);
        brk = 1; retire = 1; tick(1);
        clear_ev(); devna = 1; retire = 1; set_ip(32'h808, 2); tick(3);   // ignored while held
        clear_ev(); tick(1); ack = 1; tick(1); ack = 0; tick(1);
        devna = 1; retire = 1; set_ip(32'h820, 2); tick(1);
        clear_ev(); ack = 1; tick(1);                  // ack in the pulse cycle
        ack = 0; devna = 1; retire = 1; set_ip(32'h830, 2); tick(1);
        clear_ev(); tick(1); ack = 1; tick(1); ack = 0; tick(1);

        cur_req = "R11"; set_ip(32'h900, 2);
        badop = 1; opcode = 8'hC4; run_instr();
        tick(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule